// File: doc/BRIEF.md
# Bidirectional Universal Shift Register with Shared Parallel Port

This block is an eight-stage register with four clocked modes: hold, shift toward the high end, shift toward the low end and parallel capture. A single parallel port carries data both in and out. Here it is modelled as three signals: a data-in bus, a data-out bus and a port-drive enable. A pad ring or a wrapper can merge them into one tri-state bus. The register lets go of the port on its own whenever a parallel capture is selected. Two output-enable lines, both active low, can also release the port. They never affect the register contents.

Stage A is the low end (bit 0) and stage H is the high end (bit WIDTH-1). A serial input sits at each end. Two serial taps always show stage A and stage H, so several blocks can be chained even while the parallel port is released. An active-low asynchronous clear zeroes every stage and wins over every other input.

Top module: `shreg_top`

## Requirements
- R1: With mode code {sel_lft, sel_rgt} = 2'b00, a rising clock edge leaves every stage unchanged.
- R2: With mode code 2'b01 (shift right), a rising edge loads ser_in_a into stage A (bit 0), and each stage n takes the old value of stage n-1.
- R3: With mode code 2'b10 (shift left), a rising edge loads ser_in_h into stage H (bit WIDTH-1), and each stage n takes the old value of stage n+1.
- R4: With mode code 2'b11 (parallel capture), a rising edge copies port_in into the stages bit for bit.
- R5: While rst_n is low, all stages read zero at once, whatever the clock, mode or data inputs do.
- R6: When oe_a_n or oe_b_n is high, port_drive is low. Holding, shifting, capturing and clearing go on unchanged.
- R7: In mode 2'b11, port_drive is low whatever the output enables are, so an external driver may use the port.
- R8: With both output enables low and a mode other than 2'b11, port_drive is high and port_out shows stages A..H on bits 0..WIDTH-1.
- R9: tap_a always equals stage A and tap_h always equals stage H, whatever the output enables are.
- R10: During reset, port_out and both taps read zero. port_drive is still high when both enables are low and the mode is not 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel_rgt | input | 1 | Mode select, low bit of the mode code |
| sel_lft | input | 1 | Mode select, high bit of the mode code |
| oe_a_n | input | 1 | Port output enable, active low |
| oe_b_n | input | 1 | Port output enable, active low |
| ser_in_a | input | 1 | Serial input at the stage A end |
| ser_in_h | input | 1 | Serial input at the stage H end |
| port_in | input | WIDTH | Parallel data arriving from the shared port |
| port_out | output | WIDTH | Stage values offered to the shared port |
| port_drive | output | 1 | High when the block drives the shared port |
| tap_a | output | 1 | Always-driven copy of stage A |
| tap_h | output | 1 | Always-driven copy of stage H |

## Verification
The hardest case to reach is the handover of the shared port. A capture must land on the very cycle the block has let go of the bus, and the external driver must never overlap the block's own drive. The bench models that driver: it drives the bus only while it selects capture mode and flags any overlap with port_drive. Random mode changes, including rapid switches between capture and shift, push this handover through every mix of enables. An asynchronous clear is asserted directly between clock edges, and the clock keeps running under capture mode while the clear is held, to show that the clear overrides the clock.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // Mode code is {sel_lft, sel_rgt}
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } shreg_mode_e;

endpackage

// File: rtl/shreg_mode_decode.sv
module shreg_mode_decode
    import shreg_pkg::*;
(
    input  logic        sel_rgt,
    input  logic        sel_lft,
    output shreg_mode_e mode,
    output logic        port_release
);
    always_comb begin
        mode         = shreg_mode_e'({sel_lft, sel_rgt});
        port_release = (mode == MODE_LOAD);
    end
endmodule

// File: rtl/shreg_next.sv
module shreg_next
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  shreg_mode_e      mode,
    input  logic             ser_in_a,
    input  logic             ser_in_h,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] nxt
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] toward_h;
    logic [WIDTH-1:0] toward_a;

    // Stage-by-stage neighbour selection
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_stage
            if (g == 0) begin : g_low
                assign toward_h[g] = ser_in_a;
            end else begin : g_low_n
                assign toward_h[g] = cur[g-1];
            end
            if (g == TOP) begin : g_high
                assign toward_a[g] = ser_in_h;
            end else begin : g_high_n
                assign toward_a[g] = cur[g+1];
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_RIGHT: nxt = toward_h;
            MODE_LEFT:  nxt = toward_a;
            MODE_LOAD:  nxt = port_in;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/shreg_port_gate.sv
module shreg_port_gate (
    input  logic oe_a_n,
    input  logic oe_b_n,
    input  logic port_release,
    output logic port_drive
);
    always_comb begin
        port_drive = 1'b1;
        if (oe_a_n || oe_b_n) port_drive = 1'b0;
        if (port_release)     port_drive = 1'b0;
    end
endmodule

// File: rtl/shreg_top.sv
module shreg_top
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_rgt,
    input  logic             sel_lft,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_in_a,
    input  logic             ser_in_h,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] port_out,
    output logic             port_drive,
    output logic             tap_a,
    output logic             tap_h
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } state_t;

    state_t      st_d, st_q;
    shreg_mode_e mode;
    logic        port_release;
    logic [WIDTH-1:0] nxt_stages;

    shreg_mode_decode u_decode (
        .sel_rgt      (sel_rgt),
        .sel_lft      (sel_lft),
        .mode         (mode),
        .port_release (port_release)
    );

    shreg_next #(.WIDTH(WIDTH)) u_next (
        .cur      (st_q.stages),
        .mode     (mode),
        .ser_in_a (ser_in_a),
        .ser_in_h (ser_in_h),
        .port_in  (port_in),
        .nxt      (nxt_stages)
    );

    shreg_port_gate u_gate (
        .oe_a_n       (oe_a_n),
        .oe_b_n       (oe_b_n),
        .port_release (port_release),
        .port_drive   (port_drive)
    );

    always_comb begin
        st_d        = st_q;
        st_d.stages = nxt_stages;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign port_out = st_q.stages;
    assign tap_a    = st_q.stages[0];
    assign tap_h    = st_q.stages[TOP];
endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_rgt,
    input logic             sel_lft,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_in_a,
    input logic             ser_in_h,
    input logic [WIDTH-1:0] port_in,
    input logic [WIDTH-1:0] port_out,
    input logic             port_drive,
    input logic             tap_a,
    input logic             tap_h
);
    localparam int TOP = WIDTH - 1;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lft && !sel_rgt) |=> $stable(port_out));

    assert_shift_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lft && sel_rgt) |=>
            (port_out == {$past(port_out[TOP-1:0]), $past(ser_in_a)}));

    assert_shift_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lft && !sel_rgt) |=>
            (port_out == {$past(ser_in_h), $past(port_out[TOP:1])}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lft && sel_rgt) |=> (port_out == $past(port_in)));

    assert_clear_R5: assert property (@(posedge clk)
        !rst_n |-> (port_out == '0));

    assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !port_drive);

    assert_load_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lft && sel_rgt) |-> !port_drive);

    assert_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && !(sel_lft && sel_rgt)) |-> port_drive);

    assert_taps_R9: assert property (@(posedge clk)
        (tap_a == port_out[0]) && (tap_h == port_out[TOP]));

    assert_reset_taps_R10: assert property (@(posedge clk)
        !rst_n |-> (!tap_a && !tap_h));
endmodule

bind shreg_top shreg_checker #(.WIDTH(WIDTH)) u_shreg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_rgt    (sel_rgt),
    .sel_lft    (sel_lft),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .ser_in_a   (ser_in_a),
    .ser_in_h   (ser_in_h),
    .port_in    (port_in),
    .port_out   (port_out),
    .port_drive (port_drive),
    .tap_a      (tap_a),
    .tap_h      (tap_h)
);

// File: tb/shreg_top_bench.sv
`timescale 1ns/1ps
module shreg_top_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_rgt = 1'b0, sel_lft = 1'b0;
    logic         oe_a_n = 1'b0, oe_b_n = 1'b0;
    logic         ser_in_a = 1'b0, ser_in_h = 1'b0;
    logic [W-1:0] port_in = '0;
    logic [W-1:0] port_out;
    logic         port_drive, tap_a, tap_h;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model = '0;

    always #2.5 clk = ~clk;

    shreg_top #(.WIDTH(W)) u_shreg_top (
        .clk(clk), .rst_n(rst_n), .sel_rgt(sel_rgt), .sel_lft(sel_lft),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_in_a(ser_in_a),
        .ser_in_h(ser_in_h), .port_in(port_in), .port_out(port_out),
        .port_drive(port_drive), .tap_a(tap_a), .tap_h(tap_h)
    );

    function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic sl,
            logic sr, logic a_in, logic h_in, logic [W-1:0] pin);
        case ({sl, sr})
            2'b01:   return {cur[W-2:0], a_in};
            2'b10:   return {h_in, cur[W-1:1]};
            2'b11:   return pin;
            default: return cur;
        endcase
    endfunction

    function automatic logic exp_drive(logic sl, logic sr, logic oa, logic ob);
        return !oa && !ob && !(sl && sr);
    endfunction

    function automatic string tag_of(logic sl, logic sr);
        case ({sl, sr})
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        check(req, port_out, model);
        check("R9", {7'd0, tap_a}, {7'd0, model[0]});
        check("R9", {7'd0, tap_h}, {7'd0, model[W-1]});
    endtask

    task automatic check_drive();
        string r;
        if (sel_lft && sel_rgt)  r = "R7";
        else if (oe_a_n || oe_b_n) r = "R6";
        else                     r = "R8";
        check(r, {7'd0, port_drive},
              {7'd0, exp_drive(sel_lft, sel_rgt, oe_a_n, oe_b_n)});
        // external bus driver is active only in capture mode
        if ((sel_lft && sel_rgt) && port_drive) begin
            checks++; fails++;
            $display("FAIL R7 bus contention actual=1 expected=0");
        end
    endtask

    // one cycle: drive inputs at negedge, model the posedge, check at next negedge
    task automatic step(logic sl, logic sr, logic oa, logic ob,
                        logic a_in, logic h_in, logic [W-1:0] pin);
        string t;
        sel_lft = sl; sel_rgt = sr; oe_a_n = oa; oe_b_n = ob;
        ser_in_a = a_in; ser_in_h = h_in;
        port_in = (sl && sr) ? pin : 'x;
        if (!(sl && sr)) port_in = '0;
        #1;
        check_drive();
        t = tag_of(sl, sr);
        if (oa || ob) t = {t, "/R6"};
        model = next_val(model, sl, sr, a_in, h_in, port_in);
        @(negedge clk);
        check_outputs(t);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // reset state, with drive enabled in hold mode (R10, R5)
        #3;
        check("R10", port_out, '0);
        check("R10", {6'd0, tap_a, tap_h}, '0);
        check("R10", {7'd0, port_drive}, 8'd1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        model = '0;

        // directed corners
        step(1, 1, 0, 0, 0, 0, 8'hA5);   // R4 capture
        step(0, 0, 0, 0, 1, 1, 8'h00);   // R1 hold
        step(0, 1, 0, 0, 1, 0, 8'h00);   // R2 right with one
        step(1, 0, 0, 0, 0, 1, 8'h00);   // R3 left with one
        step(1, 1, 1, 1, 0, 0, 8'h3C);   // R7 capture with enables high
        step(0, 1, 1, 0, 1, 0, 8'h00);   // R6 shift while released
        step(1, 0, 0, 1, 0, 1, 8'h00);   // R6 shift while released
        for (int i = 0; i < W; i++) step(0, 1, 0, 0, 1, 0, 8'h00); // fill with ones
        step(1, 1, 0, 0, 0, 0, 8'h81);   // R4 edge bits
        for (int i = 0; i < W; i++) step(1, 0, 0, 0, 0, 0, 8'h00); // drain to zero

        // asynchronous clear mid-cycle, clock running in capture mode (R5, R10)
        step(1, 1, 0, 0, 0, 0, 8'hFF);
        #1; rst_n = 1'b0; #0.5;
        check("R5", port_out, '0);
        sel_lft = 1; sel_rgt = 1; port_in = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5", port_out, '0);
        sel_lft = 0; sel_rgt = 0; oe_a_n = 0; oe_b_n = 0; #1;
        check("R10", {7'd0, port_drive}, 8'd1);
        check("R10", {6'd0, tap_a, tap_h}, '0);
        rst_n = 1'b1;
        model = '0;
        @(negedge clk);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r = 4'($urandom);
            step(r[0], r[1], ($urandom % 4) == 0, ($urandom % 4) == 0,
                 r[2], r[3], 8'($urandom));
        end
        finish_run();
    end
endmodule